// File: doc/BRIEF.md
# Automatic Record Level Controller

This block closes a digital gain loop around a record amplifier. It watches the left and right sample streams that come back from the converter, tracks the peak magnitude seen in the current timing window, and nudges a 6-bit record gain code down when the peak exceeds a programmable target and up when it falls short. The result is a recording level that stays near the target whatever the input amplitude.

Timing is counted in sample strobes, not clock cycles. An over-target peak triggers an attack window, after which the gain drops by one code. An under-target peak first waits out a hold window and then raises the gain one code per decay window. A ceiling derived from a 3-bit field bounds how far the loop may raise the gain, and a noise gate freezes the gain when the input is so quiet that raising it would only amplify noise. In stereo the larger of the two channel peaks drives one shared gain, so the stereo image is kept. In a single-channel mode the other channel's samples are ignored. When the loop is off, the manual codes pass straight through.

Top module: `alc_ctrl`

## Requirements
- R1: With `cfg_mode` = 2'b00 (off), `gain_l` equals `man_gain_l` and `gain_r` equals `man_gain_r` on every cycle.
- R2: With `cfg_mode` = 2'b11 (stereo), the loop is driven by the larger of the two channel peaks, and one shared gain appears on both `gain_l` and `gain_r`.
- R3: With `cfg_mode` = 2'b10 (left only) the loop uses only left samples and `gain_r` equals `man_gain_r`. With 2'b01 (right only) it uses only right samples and `gain_l` equals `man_gain_l`. Samples of the unused channel have no effect on the gain.
- R4: On any change of `cfg_mode` into a loop mode, the loop gain restarts from the manual code of the controlled channel (`man_gain_r` for right only, `man_gain_l` otherwise), and the window counter and peak are cleared.
- R5: The peak level is magnitude bits [14:11] of the two's-complement sample (the most negative sample is taken as full scale). When the level exceeds `cfg_target`, the gain drops by one code each time 2^`cfg_attack` strobes have elapsed since the last window end.
- R6: When the level is below `cfg_target`, the gain is unchanged for a hold window of 2^`cfg_hold` strobes, and then rises by one code at the end of each decay window of 2^`cfg_decay` strobes.
- R7: When the level equals `cfg_target`, the gain does not change.
- R8: The gain ceiling is {`cfg_maxgain`, 3'b111}. The loop never steps the gain above it. A gain above the ceiling is brought down to the ceiling at the next window end.
- R9: The gain never steps below code 0.
- R10: When `cfg_gate_en` is 1 and peak magnitude bits [14:10] are below `cfg_gate_thr`, a decay window end does not raise the gain.
- R11: With the mode held, the loop gain changes only on a cycle with `smp_vld` high. Apart from a clamp to the ceiling, it changes by at most one code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample pair |
| smp_l | input | 16 | Left sample, two's complement |
| smp_r | input | 16 | Right sample, two's complement |
| cfg_mode | input | 2 | 00 off, 01 right only, 10 left only, 11 stereo |
| cfg_target | input | 4 | Target peak level |
| cfg_attack | input | 4 | Attack window exponent |
| cfg_hold | input | 4 | Hold window exponent |
| cfg_decay | input | 4 | Decay window exponent |
| cfg_maxgain | input | 3 | Upper bits of the gain ceiling |
| cfg_gate_en | input | 1 | Noise gate enable |
| cfg_gate_thr | input | 5 | Noise gate threshold level |
| man_gain_l | input | 6 | Manual left gain code |
| man_gain_r | input | 6 | Manual right gain code |
| gain_l | output | 6 | Left record gain code |
| gain_r | output | 6 | Right record gain code |

## Verification
The bound checker watches the loop gain register on every cycle. It confirms that the gain moves only on strobes and by single codes, never rises past the ceiling, never rises while the gate is closed, and only falls on an attack step or a ceiling clamp. The rates themselves can only be shown by the bench's step scenarios: the number of strobes per attack step, the hold delay before decay, the restart from manual codes on a mode change, and the max-of-both stereo detection. The same holds for the immunity of single-channel modes to the other channel.

// File: rtl/alc_pkg.sv
package alc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_LEFT  = 2'b10,
    MODE_BOTH  = 2'b11
  } alc_mode_e;

  localparam int NUM_CH = 2;
  localparam int CH_L   = 0;
  localparam int CH_R   = 1;

endpackage

// File: rtl/alc_peak.sv
module alc_peak #(
  parameter int SMP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic                    clr,
  input  logic signed [SMP_W-1:0] smp,
  output logic [SMP_W-2:0]        pk_now
);

  logic [SMP_W-1:0] neg;
  logic [SMP_W-2:0] mag;
  logic [SMP_W-2:0] pk_q;
  logic [SMP_W-2:0] pk_d;

  always_comb begin
    neg = ~smp + 1'b1;
    if (smp[SMP_W-1]) begin
      mag = neg[SMP_W-1] ? '1 : neg[SMP_W-2:0];
    end else begin
      mag = smp[SMP_W-2:0];
    end
    pk_now = (smp_vld && (mag > pk_q)) ? mag : pk_q;
  end

  always_comb begin
    if (clr) begin
      pk_d = '0;
    end else if (smp_vld) begin
      pk_d = pk_now;
    end else begin
      pk_d = pk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk_q <= '0;
    end else begin
      pk_q <= pk_d;
    end
  end

endmodule

// File: rtl/alc_timer.sv
module alc_timer #(
  parameter int TIME_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic              load,
  input  logic              over,
  input  logic              under,
  input  logic [TIME_W-1:0] t_attack,
  input  logic [TIME_W-1:0] t_hold,
  input  logic [TIME_W-1:0] t_decay,
  output logic              win_end,
  output logic              step_dn,
  output logic              step_up
);

  localparam int CNT_W = 1 << TIME_W;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              held_q, held_d;
  logic [TIME_W-1:0] sel;
  logic [CNT_W:0]    win_len;
  logic [CNT_W:0]    cnt_inc;

  always_comb begin
    if (over) begin
      sel = t_attack;
    end else if (under) begin
      sel = held_q ? t_decay : t_hold;
    end else begin
      sel = t_attack;
    end
    win_len = {{CNT_W{1'b0}}, 1'b1} << sel;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    win_end = smp_vld && !load && (cnt_inc >= win_len);
    step_dn = win_end && over;
    step_up = win_end && under && held_q;
  end

  always_comb begin
    cnt_d  = cnt_q;
    held_d = held_q;
    if (load) begin
      cnt_d  = '0;
      held_d = 1'b0;
    end else if (win_end) begin
      cnt_d  = '0;
      held_d = under;
    end else if (smp_vld) begin
      cnt_d  = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      held_q <= held_d;
    end
  end

endmodule

// File: rtl/alc_gain.sv
module alc_gain #(
  parameter int GAIN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [GAIN_W-1:0] seed,
  input  logic              win_end,
  input  logic              step_dn,
  input  logic              step_up,
  input  logic              gated,
  input  logic [GAIN_W-1:0] cap,
  output logic [GAIN_W-1:0] g
);

  logic [GAIN_W-1:0] g_d;

  always_comb begin
    g_d = g;
    if (load) begin
      g_d = seed;
    end else if (win_end) begin
      if (g > cap) begin
        g_d = cap;
      end else if (step_dn && (g != '0)) begin
        g_d = g - 1'b1;
      end else if (step_up && !gated && (g < cap)) begin
        g_d = g + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g <= '0;
    end else begin
      g <= g_d;
    end
  end

endmodule

// File: rtl/alc_ctrl.sv
module alc_ctrl
  import alc_pkg::*;
#(
  parameter int SMP_W  = 16,
  parameter int GAIN_W = 6,
  parameter int TIME_W = 4,
  parameter int LVL_W  = 4,
  parameter int GATE_W = 5,
  parameter int MAXG_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic signed [SMP_W-1:0] smp_l,
  input  logic signed [SMP_W-1:0] smp_r,
  input  logic [1:0]              cfg_mode,
  input  logic [LVL_W-1:0]        cfg_target,
  input  logic [TIME_W-1:0]       cfg_attack,
  input  logic [TIME_W-1:0]       cfg_hold,
  input  logic [TIME_W-1:0]       cfg_decay,
  input  logic [MAXG_W-1:0]       cfg_maxgain,
  input  logic                    cfg_gate_en,
  input  logic [GATE_W-1:0]       cfg_gate_thr,
  input  logic [GAIN_W-1:0]       man_gain_l,
  input  logic [GAIN_W-1:0]       man_gain_r,
  output logic [GAIN_W-1:0]       gain_l,
  output logic [GAIN_W-1:0]       gain_r
);

  localparam int MAG_W = SMP_W - 1;

  logic [1:0]              mode_q;
  logic                    load;
  logic                    win_end;
  logic                    step_dn;
  logic                    step_up;
  logic                    over;
  logic                    under;
  logic                    gated;
  logic [MAG_W-1:0]        pk_ch [NUM_CH];
  logic [MAG_W-1:0]        pk_sel;
  logic [LVL_W-1:0]        lvl;
  logic [GATE_W-1:0]       lvl_gate;
  logic [GAIN_W-1:0]       cap;
  logic [GAIN_W-1:0]       seed;
  logic [GAIN_W-1:0]       gain_q;
  logic signed [SMP_W-1:0] smp_ch [NUM_CH];

  assign smp_ch[CH_L] = smp_l;
  assign smp_ch[CH_R] = smp_r;

  // restart the loop whenever the mode is off or has just changed
  assign load = (cfg_mode == MODE_OFF) || (cfg_mode != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
    end else begin
      mode_q <= cfg_mode;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_peak
    alc_peak #(.SMP_W(SMP_W)) u_peak (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_vld (smp_vld),
      .clr     (win_end || load),
      .smp     (smp_ch[ch]),
      .pk_now  (pk_ch[ch])
    );
  end

  always_comb begin
    case (cfg_mode)
      MODE_LEFT:  pk_sel = pk_ch[CH_L];
      MODE_RIGHT: pk_sel = pk_ch[CH_R];
      default:    pk_sel = (pk_ch[CH_L] > pk_ch[CH_R]) ? pk_ch[CH_L] : pk_ch[CH_R];
    endcase
    lvl      = pk_sel[MAG_W-1 -: LVL_W];
    lvl_gate = pk_sel[MAG_W-1 -: GATE_W];
    over     = lvl > cfg_target;
    under    = lvl < cfg_target;
    gated    = cfg_gate_en && (lvl_gate < cfg_gate_thr);
    cap      = {cfg_maxgain, {(GAIN_W-MAXG_W){1'b1}}};
    seed     = (cfg_mode == MODE_RIGHT) ? man_gain_r : man_gain_l;
  end

  alc_timer #(.TIME_W(TIME_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .load     (load),
    .over     (over),
    .under    (under),
    .t_attack (cfg_attack),
    .t_hold   (cfg_hold),
    .t_decay  (cfg_decay),
    .win_end  (win_end),
    .step_dn  (step_dn),
    .step_up  (step_up)
  );

  alc_gain #(.GAIN_W(GAIN_W)) u_gain (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .seed    (seed),
    .win_end (win_end),
    .step_dn (step_dn),
    .step_up (step_up),
    .gated   (gated),
    .cap     (cap),
    .g       (gain_q)
  );

  always_comb begin
    gain_l = cfg_mode[1] ? gain_q : man_gain_l;
    gain_r = cfg_mode[0] ? gain_q : man_gain_r;
  end

endmodule

// File: rtl/alc_ctrl_chk.sv
module alc_ctrl_chk #(
  parameter int GAIN_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_vld,
  input logic              load,
  input logic              step_dn,
  input logic              gated,
  input logic [GAIN_W-1:0] cap,
  input logic [GAIN_W-1:0] g
);

  // R11
  strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && !$past(smp_vld)) |-> $stable(g));

  // R11
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && ($past(g) <= $past(cap))) |->
      ((g == $past(g)) || ({1'b0, g} == {1'b0, $past(g)} + 1'b1) ||
       ({1'b0, g} + 1'b1 == {1'b0, $past(g)})));

  // R8
  ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && (g > $past(g))) |-> (g <= $past(cap)));

  // R10
  gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(gated)) |-> (g <= $past(g)));

  // R5
  down_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && (g < $past(g))) |-> ($past(step_dn) || ($past(g) > $past(cap))));

endmodule

bind alc_ctrl alc_ctrl_chk #(.GAIN_W(GAIN_W)) u_alc_ctrl_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .smp_vld (smp_vld),
  .load    (load),
  .step_dn (step_dn),
  .gated   (gated),
  .cap     (cap),
  .g       (gain_q)
);

// File: tb/alc_ctrl_bench.sv
`timescale 1ns/1ps
module alc_ctrl_bench;

  logic               clk;
  logic               rst_n;
  logic               smp_vld;
  logic signed [15:0] smp_l, smp_r;
  logic [1:0]         cfg_mode;
  logic [3:0]         cfg_target, cfg_attack, cfg_hold, cfg_decay;
  logic [2:0]         cfg_maxgain;
  logic               cfg_gate_en;
  logic [4:0]         cfg_gate_thr;
  logic [5:0]         man_gain_l, man_gain_r;
  logic [5:0]         gain_l, gain_r;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    int    l;
    int    r;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  localparam logic signed [15:0] LOUD  = 16'sh7000; // level 14
  localparam logic signed [15:0] NLOUD = -16'sh7000;
  localparam logic signed [15:0] BAND  = 16'sh4000; // level 8
  localparam logic signed [15:0] QUIET = 16'sh1000; // level 2, gate level 4

  alc_ctrl u_alc_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_vld      (smp_vld),
    .smp_l        (smp_l),
    .smp_r        (smp_r),
    .cfg_mode     (cfg_mode),
    .cfg_target   (cfg_target),
    .cfg_attack   (cfg_attack),
    .cfg_hold     (cfg_hold),
    .cfg_decay    (cfg_decay),
    .cfg_maxgain  (cfg_maxgain),
    .cfg_gate_en  (cfg_gate_en),
    .cfg_gate_thr (cfg_gate_thr),
    .man_gain_l   (man_gain_l),
    .man_gain_r   (man_gain_r),
    .gain_l       (gain_l),
    .gain_r       (gain_r)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic compare(string tag, int el, int er);
    total++;
    if (gain_l != el[5:0] || gain_r != er[5:0]) begin
      bad++;
      $display("FAIL %s: gain_l=%0d gain_r=%0d expected l=%0d r=%0d",
               tag, gain_l, gain_r, el, er);
    end
  endtask

  // driver: queue the expectation, strobe one sample pair, then confirm it holds
  task automatic drive(logic signed [15:0] sl, logic signed [15:0] sr,
                       int el, int er, string tag);
    exp_t e;
    e.l = el; e.r = er; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    smp_l   = sl;
    smp_r   = sr;
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (2) @(negedge clk);
    compare({tag, " R11 hold between strobes"}, el, er);
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk);
    cfg_mode = m;
    repeat (2) @(negedge clk);
  endtask

  // monitor: pop and compare right after each strobe edge
  initial begin
    forever begin
      @(posedge clk);
      if (smp_vld === 1'b1) begin
        #1;
        if (sb_q.size() == 0) begin
          total++;
          bad++;
          $display("FAIL scoreboard: empty queue, actual l=%0d r=%0d expected none",
                   gain_l, gain_r);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          compare(e.tag, e.l, e.r);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n        = 1'b0;
    smp_vld      = 1'b0;
    smp_l        = '0;
    smp_r        = '0;
    cfg_mode     = 2'b00;
    cfg_target   = 4'd8;
    cfg_attack   = 4'd2;
    cfg_hold     = 4'd3;
    cfg_decay    = 4'd1;
    cfg_maxgain  = 3'd5;
    cfg_gate_en  = 1'b0;
    cfg_gate_thr = 5'd8;
    man_gain_l   = 6'd40;
    man_gain_r   = 6'd17;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state and off-mode pass-through
    compare("R1 off mode after reset", 40, 17);
    drive(LOUD, LOUD, 40, 17, "R1 off mode ignores samples");

    // R2 R4 R5: stereo, only right channel loud, attack every 4 strobes
    set_mode(2'b11);
    for (int k = 1; k <= 12; k++)
      drive(QUIET, NLOUD, 40 - k / 4, 40 - k / 4, "R2 R4 R5 stereo attack");

    // R6 R8: quiet input, hold 8 strobes, decay every 2, ceiling 39
    cfg_maxgain = 3'd4;
    for (int k = 1; k <= 24; k++) begin
      int ev;
      ev = (k < 8) ? 37 : 37 + (k - 8) / 2;
      if (ev > 39) ev = 39;
      drive(QUIET, QUIET, ev, ev, "R6 R8 hold decay ceiling");
    end

    // R7: level equal to target
    for (int k = 1; k <= 16; k++)
      drive(BAND, BAND, 39, 39, "R7 in band");

    // R10: noise gate freezes the gain on quiet input
    set_mode(2'b00);
    man_gain_l  = 6'd20;
    cfg_gate_en = 1'b1;
    set_mode(2'b11);
    for (int k = 1; k <= 24; k++)
      drive(QUIET, QUIET, 20, 20, "R10 gate frozen");
    cfg_gate_en = 1'b0;

    // R3: left only, loud right samples ignored
    set_mode(2'b00);
    man_gain_r = 6'd50;
    set_mode(2'b10);
    for (int k = 1; k <= 16; k++)
      drive(BAND, LOUD, 20, 50, "R3 left only");

    // R3 R4 R5: right only, seeded from right manual code
    set_mode(2'b00);
    man_gain_r = 6'd30;
    cfg_attack = 4'd1;
    set_mode(2'b01);
    for (int k = 1; k <= 8; k++)
      drive(QUIET, LOUD, 20, 30 - k / 2, "R3 R4 R5 right only");

    // R8: seed above ceiling is clamped at the first window end
    set_mode(2'b00);
    man_gain_l = 6'd60;
    cfg_attack = 4'd2;
    set_mode(2'b11);
    for (int k = 1; k <= 8; k++) begin
      int ev;
      ev = (k < 4) ? 60 : 39;
      drive(BAND, BAND, ev, ev, "R8 clamp to ceiling");
    end

    // R9: floor at code 0, attack every strobe
    set_mode(2'b00);
    man_gain_l = 6'd2;
    cfg_attack = 4'd0;
    set_mode(2'b11);
    for (int k = 1; k <= 6; k++) begin
      int ev;
      ev = (2 - k < 0) ? 0 : 2 - k;
      drive(LOUD, LOUD, ev, ev, "R9 floor");
    end

    // R1: back to off mode
    set_mode(2'b00);
    compare("R1 off mode restored", 2, 30);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule